// File: doc/BRIEF.md
# Add-Compare-Select Unit for a Four-State Trellis

This block advances the path metrics of a rate-1/2, constraint-length-3 convolutional code by one trellis step each time a fresh set of branch metrics arrives. The trellis has four states. For every state the unit adds a branch metric to the metric of each of its two possible previous states. It then keeps the smaller of the two sums and records which previous state won. The four decision bits go to a survivor store that sits outside this block. The index of the state that currently holds the best metric is also available, so a traceback can start from it.

The absolute metrics grow without bound, but the gap between any two of them stays small, so the metric register width is fixed. A parameter selects how that width is kept in range. In the first mode the registers wrap freely, and every comparison looks at the sign of a modular difference. In the second mode a fixed threshold is taken off all metrics in the same cycle once every one of them has reached it.

Top module: `acs_radix2`

## Requirements
- R1: After reset, state 0 holds metric 0, states 1 to 3 hold INIT_HI, and dec_valid is 0.
- R2: State s is {s[1],s[0]}. Input bit u moves state s to state {u,s[1]}, and the encoder emits c0=u^s[1]^s[0] (generator 7 octal) and c1=u^s[0] (generator 5 octal). The branch metric for that transition is the slice bm[(2*c0+c1)*BM_W +: BM_W]. The candidate for a state is the metric of the previous state plus this branch metric.
- R3: The two previous states of state n are {n[0],0} and {n[0],1}. The smaller candidate becomes the new metric, and decision bit n is 1 when the odd previous state wins. On a tie the even previous state wins and the bit is 0.
- R4: Metrics and decisions update on the clock edge where bm_valid is 1. dec_valid is 1 for exactly the following cycle, and dec holds that step's decisions.
- R5: A cycle with bm_valid low leaves every path metric unchanged.
- R6: With WRAP=1, each stored metric equals the true unbounded metric modulo 2^PM_W. Selections stay correct across wraps, because any two metrics differ by less than 2^(PM_W-1).
- R7: With WRAP=0, once every new metric is at least THRESH, THRESH is subtracted from all of them in the same update. At least one stored metric is always below THRESH.
- R8: best_state is the index of the smallest current metric, using the modular compare when WRAP=1. On a tie the lowest index is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bm_valid | input | 1 | A new set of branch metrics is present |
| bm | input | 4*BM_W | Branch metrics indexed by code symbol 2*c0+c1 |
| pm_out | output | 4*PM_W | Path metrics, state i in slice i*PM_W |
| dec_valid | output | 1 | Decisions of the last update are valid |
| dec | output | 4 | Per-state decision bit, 1 = odd previous state won |
| best_state | output | 2 | State holding the smallest metric |

## Verification
The hardest case to reach is a comparison made while the two candidates straddle the wrap point of the metric registers. One sum has overflowed and the other has not, so a plain magnitude compare would choose the wrong path. The stimulus runs thousands of steps with random branch metrics of up to seven, which pushes the metrics around the 8-bit range many times. Each output is compared with an unbounded integer model. Stretches of all-equal branch metrics force ties in every state, and hard-decision distances taken from a noisy encoded stream keep the best path clearly ahead of the others.

// File: rtl/acs_radix2.sv
module acs_radix2 #(
  parameter int BM_W    = 3,
  parameter int PM_W    = 8,
  parameter bit WRAP    = 1'b1,
  parameter int THRESH  = 64,
  parameter int INIT_HI = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bm_valid,
  input  logic [4*BM_W-1:0]   bm,
  output logic [4*PM_W-1:0]   pm_out,
  output logic                dec_valid,
  output logic [3:0]          dec,
  output logic [1:0]          best_state
);
  localparam int NS = 4;

  logic [PM_W-1:0] pm   [NS];
  logic [PM_W-1:0] cand [NS];
  logic [NS-1:0]   pick;
  logic [NS-1:0]   at_thr;

  function automatic logic lt(input logic [PM_W-1:0] a, input logic [PM_W-1:0] b);
    logic [PM_W-1:0] d;
    d = a - b;
    return WRAP ? d[PM_W-1] : (a < b);
  endfunction

  for (genvar n = 0; n < NS; n++) begin : g_st
    localparam int P0 = (n & 1) << 1;
    localparam int P1 = P0 | 1;
    localparam int U  = n >> 1;
    localparam int S0 = (((U ^ (P0 >> 1) ^ P0) & 1) << 1) | ((U ^ P0) & 1);
    localparam int S1 = (((U ^ (P1 >> 1) ^ P1) & 1) << 1) | ((U ^ P1) & 1);
    logic [PM_W-1:0] ca, cb;
    assign ca        = pm[P0] + PM_W'(bm[S0*BM_W +: BM_W]);
    assign cb        = pm[P1] + PM_W'(bm[S1*BM_W +: BM_W]);
    assign pick[n]   = lt(cb, ca);
    assign cand[n]   = pick[n] ? cb : ca;
    assign at_thr[n] = cand[n] >= PM_W'(THRESH);
    assign pm_out[n*PM_W +: PM_W] = pm[n];
  end

  wire do_sub = !WRAP && (&at_thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) pm[i] <= (i == 0) ? '0 : PM_W'(INIT_HI);
      dec_valid <= 1'b0;
      dec       <= '0;
    end else begin
      dec_valid <= bm_valid;
      if (bm_valid) begin
        for (int i = 0; i < NS; i++)
          pm[i] <= do_sub ? cand[i] - PM_W'(THRESH) : cand[i];
        dec <= pick;
      end
    end
  end

  always_comb begin
    best_state = 2'd0;
    for (int i = 1; i < NS; i++)
      if (lt(pm[i], pm[best_state])) best_state = 2'(i);
  end
endmodule

// File: rtl/acs_radix2_chk.sv
module acs_radix2_chk #(
  parameter int PM_W   = 8,
  parameter bit WRAP   = 1'b1,
  parameter int THRESH = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bm_valid,
  input logic [4*PM_W-1:0] pm_out,
  input logic              dec_valid,
  input logic [1:0]        best_state
);
  logic [PM_W-1:0] best_pm;
  logic [3:0]      not_worse;
  logic [3:0]      under;
  assign best_pm = pm_out[best_state*PM_W +: PM_W];
  for (genvar i = 0; i < 4; i++) begin : g_c
    logic [PM_W-1:0] m, d;
    assign m = pm_out[i*PM_W +: PM_W];
    assign d = m - best_pm;
    assign not_worse[i] = WRAP ? !d[PM_W-1] : (m >= best_pm);
    assign under[i]     = m < PM_W'(THRESH);
  end

  assert_dec_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(bm_valid));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bm_valid |=> $stable(pm_out));
  assert_best_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
    &not_worse);
  assert_spread_R6: assert property (@(posedge clk) disable iff (!rst_n)
    WRAP |-> &not_worse);
  assert_thr_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !WRAP |-> |under);
endmodule

bind acs_radix2 acs_radix2_chk #(.PM_W(PM_W), .WRAP(WRAP), .THRESH(THRESH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bm_valid(bm_valid), .pm_out(pm_out),
  .dec_valid(dec_valid), .best_state(best_state)
);

// File: tb/acs_radix2_tb.sv
`timescale 1ns/1ps
module acs_radix2_tb;
  localparam int BM_W = 3, PM_W = 8, THRESH = 64, INIT_HI = 16;

  logic clk = 0, rst_n = 0, bm_valid = 0;
  logic [4*BM_W-1:0] bm = '0;
  logic [4*PM_W-1:0] pm_w, pm_t;
  logic dv_w, dv_t;
  logic [3:0] dec_w, dec_t;
  logic [1:0] best_w, best_t;
  int n_chk = 0, n_fail = 0;
  longint rw[4], rt[4];

  always #4 clk = ~clk;

  acs_radix2 #(.BM_W(BM_W), .PM_W(PM_W), .WRAP(1'b1), .THRESH(THRESH), .INIT_HI(INIT_HI)) u_dut (
    .clk(clk), .rst_n(rst_n), .bm_valid(bm_valid), .bm(bm), .pm_out(pm_w),
    .dec_valid(dv_w), .dec(dec_w), .best_state(best_w));
  acs_radix2 #(.BM_W(BM_W), .PM_W(PM_W), .WRAP(1'b0), .THRESH(THRESH), .INIT_HI(INIT_HI)) u_dut_thr (
    .clk(clk), .rst_n(rst_n), .bm_valid(bm_valid), .bm(bm), .pm_out(pm_t),
    .dec_valid(dv_t), .dec(dec_t), .best_state(best_t));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sym(int p, int n);
    int u = n >> 1;
    return (((u ^ (p >> 1) ^ p) & 1) << 1) | ((u ^ p) & 1);
  endfunction

  task automatic advance(inout longint r[4], output logic [3:0] d, input bit thr);
    longint nr[4];
    bit all_hi = 1;
    for (int n = 0; n < 4; n++) begin
      int p0 = (n & 1) << 1;
      longint ca = r[p0] + longint'(bm[sym(p0, n)*BM_W +: BM_W]);
      longint cb = r[p0+1] + longint'(bm[sym(p0+1, n)*BM_W +: BM_W]);
      d[n] = cb < ca;
      nr[n] = d[n] ? cb : ca;
      if (nr[n] < THRESH) all_hi = 0;
    end
    for (int n = 0; n < 4; n++) r[n] = (thr && all_hi) ? nr[n] - THRESH : nr[n];
  endtask

  function automatic int best_of(longint r[4]);
    int b = 0;
    for (int i = 1; i < 4; i++) if (r[i] < r[b]) b = i;
    return b;
  endfunction

  task automatic compare_all(input string tag);
    for (int i = 0; i < 4; i++) begin
      chk(pm_w[i*PM_W +: PM_W] == PM_W'(rw[i]), {tag, " R6 wrap metric"},
          pm_w[i*PM_W +: PM_W], rw[i] & 255);
      chk(pm_t[i*PM_W +: PM_W] == PM_W'(rt[i]), {tag, " R7 thr metric"},
          pm_t[i*PM_W +: PM_W], rt[i]);
    end
    chk(best_w == 2'(best_of(rw)), {tag, " R8 best wrap"}, best_w, best_of(rw));
    chk(best_t == 2'(best_of(rt)), {tag, " R8 best thr"}, best_t, best_of(rt));
  endtask

  task automatic step(input logic [4*BM_W-1:0] v, input bit gap);
    logic [3:0] ew, et;
    @(negedge clk);
    bm = v; bm_valid = 1;
    advance(rw, ew, 0);
    advance(rt, et, 1);
    @(negedge clk);
    bm_valid = 0;
    chk(dv_w && dv_t, "R4 dec_valid", dv_w, 1);
    chk(dec_w == ew, "R3 decisions wrap", dec_w, ew);
    chk(dec_t == et, "R3 decisions thr", dec_t, et);
    compare_all("R2 update");
    if (gap) begin
      bm = {$urandom} [4*BM_W-1:0];
      @(negedge clk);
      chk(!dv_w && !dv_t, "R4 dec_valid drop", dv_w, 0);
      compare_all("R5 idle hold");
    end
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] enc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 4; i++) begin rw[i] = (i == 0) ? 0 : INIT_HI; rt[i] = rw[i]; end
    @(negedge clk);
    chk(pm_w == {PM_W'(INIT_HI), PM_W'(INIT_HI), PM_W'(INIT_HI), PM_W'(0)}, "R1 reset wrap", pm_w, 0);
    chk(pm_t == pm_w, "R1 reset thr", pm_t, pm_w);
    chk(!dv_w && !dv_t, "R1 reset dec_valid", dv_w, 0);
    compare_all("R1 reset");
    // ties everywhere
    for (int k = 0; k < 40; k++) step({4{3'(k % 8)}}, k % 3 == 0);
    // random branch metrics, many wraps
    for (int k = 0; k < 2500; k++) step({$urandom} [4*BM_W-1:0], ($urandom % 4) == 0);
    // hard-decision distances from an encoded noisy stream
    enc = 3'b000;
    for (int k = 0; k < 1500; k++) begin
      logic u, c0, c1;
      logic [4*BM_W-1:0] v;
      u = 1'($urandom);
      c0 = u ^ enc[1] ^ enc[0];
      c1 = u ^ enc[0];
      enc = {1'b0, u, enc[1]};
      if ($urandom % 10 == 0) c0 = ~c0;
      for (int s = 0; s < 4; s++)
        v[s*BM_W +: BM_W] = 3'((((s >> 1) & 1) != c0) + ((s & 1) != c1));
      step(v, ($urandom % 8) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule